// File: doc/BRIEF.md
# Register Rename Map with Free List

This block translates the eight architectural general-purpose register indices of an integer core into indices of a larger pool of physical registers. Every instruction that writes a register gets a physical register that was free, and the map entry for that architectural register is pointed at it. Because no write lands on the physical register that earlier instructions still read, write-after-read and write-after-write hazards are gone. Source operands are translated through the current map, so software sees only architectural indices.

Up to `LANES` rename requests (two by default) arrive per cycle, in program order from lane 0 upward. Each request carries two source indices and an optional destination index. For each destination the block returns the newly allocated physical register and the one it replaces, so commit logic can free the replaced register once no reader needs it. A release port returns such registers to the pool. When the pool cannot cover every destination in the cycle, the block raises `stall` and changes nothing for that cycle's requests.

Top module: `renameMap`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and only physical registers NUM_ARCH to NUM_PHYS-1 are free.
- R2: For a valid lane, `srcAPhys` and `srcBPhys` give the current mapping of `srcAArch` and `srcBArch`, combinationally in the same cycle.
- R3: Each writing lane (valid with `dstVld`) is given a free physical register on `newPhys`: the lowest-numbered free one goes to the lowest-numbered writing lane, the next-lowest to the next writing lane, and no two lanes get the same one.
- R4: `oldPhys` of a writing lane gives the physical register that its destination was mapped to before this lane's write.
- R5: A source of lane k that names a destination written by an earlier lane in the same cycle gets that earlier lane's new physical register (the latest such lane wins).
- R6: When several lanes in a cycle write the same architectural register, the map afterwards holds the latest lane's allocation, and that lane's `oldPhys` is the earlier lane's new register.
- R7: `stall` is high in the same cycle exactly when the number of writing lanes exceeds the number of free registers; in a stalled cycle neither the map nor the allocation of any register changes.
- R8: A register returned on a release lane (`relVld`, `relPhys`) becomes free at the next clock edge, is not allocatable in the cycle it is released, and releases take effect even in a stalled cycle.
- R9: A lane that is not valid, or valid without `dstVld`, consumes no physical register and alters no map entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVld | input | LANES | Lane carries a rename request |
| dstVld | input | LANES | Lane writes a destination register |
| srcAArch | input | LANES x ArchW | First source architectural index per lane |
| srcBArch | input | LANES x ArchW | Second source architectural index per lane |
| dstArch | input | LANES x ArchW | Destination architectural index per lane |
| relVld | input | LANES | Release lane active |
| relPhys | input | LANES x PhysW | Physical register being released |
| stall | output | 1 | Not enough free registers for this cycle's writes |
| srcAPhys | output | LANES x PhysW | Translated first source |
| srcBPhys | output | LANES x PhysW | Translated second source |
| newPhys | output | LANES x PhysW | Register allocated to the lane's destination |
| oldPhys | output | LANES x PhysW | Register the destination was mapped to before |

## Verification
The bench builds the block with eight architectural registers, two lanes and a pool of only twelve physical registers, so just four start free. That small pool drains within two dual-write cycles, which brings the exact boundary of one free register against one or two writers, total exhaustion, and reuse of released registers into a short sequence whose results can be worked out by hand. Same-cycle source forwarding and double writes to one register are mixed into the same sequence.

// File: rtl/renamePkg.sv
package renamePkg;

  // Strobes from the control to the datapath parts
  typedef struct packed {
    logic commit;    // this cycle's requests are accepted
    logic allocate;  // accepted and at least one lane writes
  } renameStrobes_t;

endpackage

// File: rtl/renameCtrl.sv
module renameCtrl #(
  parameter int unsigned LANES = 2,
  parameter int unsigned CNT_W = 6
) (
  input  logic [LANES-1:0]         wants,
  input  logic [CNT_W-1:0]         freeCount,
  output logic                     stall,
  output renamePkg::renameStrobes_t strb
);

  logic [CNT_W-1:0] needed;

  always_comb begin
    needed = '0;
    for (int l = 0; l < LANES; l++) begin
      needed = needed + CNT_W'(wants[l]);
    end
  end

  assign stall         = needed > freeCount;
  assign strb.commit   = !stall;
  assign strb.allocate = !stall && (|wants);

endmodule

// File: rtl/freeList.sv
module freeList #(
  parameter int unsigned NUM_ARCH = 8,
  parameter int unsigned NUM_PHYS = 32,
  parameter int unsigned LANES    = 2,
  localparam int unsigned PhysW   = $clog2(NUM_PHYS),
  localparam int unsigned CntW    = $clog2(NUM_PHYS + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  renamePkg::renameStrobes_t     strb,
  input  logic [LANES-1:0]              wants,
  input  logic [LANES-1:0]              relVld,
  input  logic [LANES-1:0][PhysW-1:0]   relPhys,
  output logic [LANES-1:0][PhysW-1:0]   allocIdx,
  output logic [CntW-1:0]               freeCount
);

  logic [NUM_PHYS-1:0] freeVec;
  logic [NUM_PHYS-1:0] nextFree;
  logic [NUM_PHYS-1:0] remaining;
  logic                found;

  // Lowest free register to each writing lane in lane order
  always_comb begin
    remaining = freeVec;
    allocIdx  = '0;
    found     = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      found = 1'b0;
      if (wants[l]) begin
        for (int p = 0; p < NUM_PHYS; p++) begin
          if (!found && remaining[p]) begin
            allocIdx[l] = PhysW'(p);
            found       = 1'b1;
          end
        end
        if (found) remaining[allocIdx[l]] = 1'b0;
      end
    end
  end

  always_comb begin
    freeCount = '0;
    for (int p = 0; p < NUM_PHYS; p++) begin
      freeCount = freeCount + CntW'(freeVec[p]);
    end
  end

  always_comb begin
    nextFree = freeVec;
    if (strb.allocate) begin
      for (int l = 0; l < LANES; l++) begin
        if (wants[l]) nextFree[allocIdx[l]] = 1'b0;
      end
    end
    for (int l = 0; l < LANES; l++) begin
      if (relVld[l]) nextFree[relPhys[l]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PHYS; p++) begin
        freeVec[p] <= (p >= NUM_ARCH);
      end
    end else begin
      freeVec <= nextFree;
    end
  end

  // R1
  no_overcount_chk: assert property (@(posedge clk) disable iff (!rstN)
    freeCount <= CntW'(NUM_PHYS - NUM_ARCH));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.commit && !(|relVld)) |=> $stable(freeVec));

  for (genvar l = 0; l < LANES; l++) begin : g_laneChk
    // R3
    alloc_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.allocate && wants[l] && !(|relVld)) |=> !freeVec[$past(allocIdx[l])]);
    // R8
    release_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
      relVld[l] |=> freeVec[$past(relPhys[l])]);
  end

endmodule

// File: rtl/mapTable.sv
module mapTable #(
  parameter int unsigned NUM_ARCH = 8,
  parameter int unsigned NUM_PHYS = 32,
  parameter int unsigned LANES    = 2,
  localparam int unsigned ArchW   = $clog2(NUM_ARCH),
  localparam int unsigned PhysW   = $clog2(NUM_PHYS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  renamePkg::renameStrobes_t     strb,
  input  logic [LANES-1:0]              wants,
  input  logic [LANES-1:0][ArchW-1:0]   srcAArch,
  input  logic [LANES-1:0][ArchW-1:0]   srcBArch,
  input  logic [LANES-1:0][ArchW-1:0]   dstArch,
  input  logic [LANES-1:0][PhysW-1:0]   allocIdx,
  output logic [LANES-1:0][PhysW-1:0]   srcAPhys,
  output logic [LANES-1:0][PhysW-1:0]   srcBPhys,
  output logic [LANES-1:0][PhysW-1:0]   oldPhys
);

  logic [NUM_ARCH-1:0][PhysW-1:0] mapTab;
  logic [NUM_ARCH-1:0][PhysW-1:0] nextMap;

  // Translation with forwarding from earlier lanes of the same cycle
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      srcAPhys[l] = mapTab[srcAArch[l]];
      srcBPhys[l] = mapTab[srcBArch[l]];
      oldPhys[l]  = mapTab[dstArch[l]];
      for (int k = 0; k < LANES; k++) begin
        if (k < l && wants[k]) begin
          if (dstArch[k] == srcAArch[l]) srcAPhys[l] = allocIdx[k];
          if (dstArch[k] == srcBArch[l]) srcBPhys[l] = allocIdx[k];
          if (dstArch[k] == dstArch[l])  oldPhys[l]  = allocIdx[k];
        end
      end
    end
  end

  always_comb begin
    nextMap = mapTab;
    for (int l = 0; l < LANES; l++) begin
      if (wants[l]) nextMap[dstArch[l]] = allocIdx[l];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < NUM_ARCH; a++) begin
        mapTab[a] <= PhysW'(a);
      end
    end else if (strb.allocate) begin
      mapTab <= nextMap;
    end
  end

  // R7
  map_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(mapTab));

  // R6
  last_writer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.allocate && wants[LANES-1])
      |=> mapTab[$past(dstArch[LANES-1])] == $past(allocIdx[LANES-1]));

  for (genvar i = 0; i < LANES; i++) begin : g_pairI
    for (genvar j = i + 1; j < LANES; j++) begin : g_pairJ
      // R3
      distinct_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strb.allocate && wants[i] && wants[j]) |-> allocIdx[i] != allocIdx[j]);
    end
  end

endmodule

// File: rtl/renameMap.sv
module renameMap #(
  parameter int unsigned NUM_ARCH = 8,
  parameter int unsigned NUM_PHYS = 32,
  parameter int unsigned LANES    = 2,
  localparam int unsigned ArchW   = $clog2(NUM_ARCH),
  localparam int unsigned PhysW   = $clog2(NUM_PHYS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [LANES-1:0]            reqVld,
  input  logic [LANES-1:0]            dstVld,
  input  logic [LANES-1:0][ArchW-1:0] srcAArch,
  input  logic [LANES-1:0][ArchW-1:0] srcBArch,
  input  logic [LANES-1:0][ArchW-1:0] dstArch,
  input  logic [LANES-1:0]            relVld,
  input  logic [LANES-1:0][PhysW-1:0] relPhys,
  output logic                        stall,
  output logic [LANES-1:0][PhysW-1:0] srcAPhys,
  output logic [LANES-1:0][PhysW-1:0] srcBPhys,
  output logic [LANES-1:0][PhysW-1:0] newPhys,
  output logic [LANES-1:0][PhysW-1:0] oldPhys
);

  localparam int unsigned CntW = $clog2(NUM_PHYS + 1);

  logic [LANES-1:0]            wants;
  logic [CntW-1:0]             freeCount;
  logic [LANES-1:0][PhysW-1:0] allocIdx;
  renamePkg::renameStrobes_t   strb;

  assign wants   = reqVld & dstVld;
  assign newPhys = allocIdx;

  renameCtrl #(.LANES(LANES), .CNT_W(CntW)) u_ctrl (
    .wants(wants), .freeCount(freeCount), .stall(stall), .strb(strb)
  );

  freeList #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .LANES(LANES)) u_free (
    .clk(clk), .rstN(rstN), .strb(strb), .wants(wants),
    .relVld(relVld), .relPhys(relPhys),
    .allocIdx(allocIdx), .freeCount(freeCount)
  );

  mapTable #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .LANES(LANES)) u_map (
    .clk(clk), .rstN(rstN), .strb(strb), .wants(wants),
    .srcAArch(srcAArch), .srcBArch(srcBArch), .dstArch(dstArch),
    .allocIdx(allocIdx),
    .srcAPhys(srcAPhys), .srcBPhys(srcBPhys), .oldPhys(oldPhys)
  );

endmodule

// File: tb/test_renameMap.sv
`timescale 1ns/1ps
module test_renameMap;

  localparam int unsigned NA = 8;
  localparam int unsigned NP = 12;
  localparam int unsigned LN = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] reqVld, dstVld, relVld;
  logic [1:0][2:0] srcAArch, srcBArch, dstArch;
  logic [1:0][3:0] relPhys;
  logic stall;
  logic [1:0][3:0] srcAPhys, srcBPhys, newPhys, oldPhys;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  renameMap #(.NUM_ARCH(NA), .NUM_PHYS(NP), .LANES(LN)) i_renameMap (
    .clk(clk), .rstN(rstN), .reqVld(reqVld), .dstVld(dstVld),
    .srcAArch(srcAArch), .srcBArch(srcBArch), .dstArch(dstArch),
    .relVld(relVld), .relPhys(relPhys), .stall(stall),
    .srcAPhys(srcAPhys), .srcBPhys(srcBPhys), .newPhys(newPhys), .oldPhys(oldPhys)
  );

  typedef struct packed {
    logic [1:0] rel;  logic [3:0] rp0;  logic [3:0] rp1;
    logic [1:0] vld;  logic [1:0] dv;
    logic [2:0] sa0;  logic [2:0] sb0;  logic [2:0] d0;
    logic [2:0] sa1;  logic [2:0] sb1;  logic [2:0] d1;
    logic       eStall;
    logic [3:0] eSa0; logic [3:0] eSb0; logic [3:0] eNew0; logic [3:0] eOld0;
    logic [3:0] eSa1; logic [3:0] eSb1; logic [3:0] eNew1; logic [3:0] eOld1;
  } vec_t;

  // Starts from the reset state; bit 0 of rel/vld/dv is lane 0
  localparam vec_t VECS [9] = '{
    '{2'b00, 4'd0, 4'd0, 2'b11, 2'b11, 3'd1, 3'd2, 3'd1, 3'd1, 3'd3, 3'd2, 1'b0,
      4'd1, 4'd2, 4'd8, 4'd1, 4'd8, 4'd3, 4'd9, 4'd2},
    '{2'b11, 4'd1, 4'd2, 2'b11, 2'b11, 3'd1, 3'd4, 3'd1, 3'd1, 3'd2, 3'd1, 1'b0,
      4'd8, 4'd4, 4'd10, 4'd8, 4'd10, 4'd9, 4'd11, 4'd10},
    '{2'b00, 4'd0, 4'd0, 2'b01, 2'b01, 3'd1, 3'd1, 3'd5, 3'd0, 3'd0, 3'd0, 1'b0,
      4'd11, 4'd11, 4'd1, 4'd5, 4'd0, 4'd0, 4'd0, 4'd0},
    '{2'b00, 4'd0, 4'd0, 2'b11, 2'b11, 3'd6, 3'd6, 3'd6, 3'd7, 3'd7, 3'd7, 1'b1,
      4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    '{2'b11, 4'd6, 4'd8, 2'b11, 2'b01, 3'd6, 3'd0, 3'd6, 3'd6, 3'd5, 3'd0, 1'b0,
      4'd6, 4'd0, 4'd2, 4'd6, 4'd2, 4'd1, 4'd0, 4'd0},
    '{2'b00, 4'd0, 4'd0, 2'b11, 2'b10, 3'd7, 3'd6, 3'd0, 3'd0, 3'd1, 3'd0, 1'b0,
      4'd7, 4'd2, 4'd0, 4'd0, 4'd0, 4'd11, 4'd6, 4'd0},
    '{2'b00, 4'd0, 4'd0, 2'b10, 2'b10, 3'd0, 3'd0, 3'd0, 3'd3, 3'd3, 3'd3, 1'b0,
      4'd0, 4'd0, 4'd0, 4'd0, 4'd3, 4'd3, 4'd8, 4'd3},
    '{2'b01, 4'd3, 4'd0, 2'b01, 2'b01, 3'd4, 3'd4, 3'd4, 3'd0, 3'd0, 3'd0, 1'b1,
      4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    '{2'b00, 4'd0, 4'd0, 2'b01, 2'b01, 3'd4, 3'd3, 3'd4, 3'd0, 3'd0, 3'd0, 1'b0,
      4'd4, 4'd8, 4'd3, 4'd4, 4'd0, 4'd0, 4'd0, 4'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] v, input logic [1:0] d,
                       input logic [2:0] a0, input logic [2:0] b0, input logic [2:0] w0,
                       input logic [2:0] a1, input logic [2:0] b1, input logic [2:0] w1,
                       input logic [1:0] r, input logic [3:0] p0, input logic [3:0] p1);
    @(negedge clk);
    reqVld = v; dstVld = d;
    srcAArch[0] = a0; srcBArch[0] = b0; dstArch[0] = w0;
    srcAArch[1] = a1; srcBArch[1] = b1; dstArch[1] = w1;
    relVld = r; relPhys[0] = p0; relPhys[1] = p1;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqVld = '0; dstVld = '0; relVld = '0;
    srcAArch = '0; srcBArch = '0; dstArch = '0; relPhys = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    doReset();

    // R1 reset map read back through the sources, reads alter nothing (R9)
    for (int i = 0; i < 2; i++) begin
      drive(2'b11, 2'b00, 3'(4*i), 3'(4*i+1), 3'd0, 3'(4*i+2), 3'(4*i+3), 3'd0,
            2'b00, 4'd0, 4'd0);
      chk("R1 no stall after reset", int'(stall), 0);
      chk("R1 reset map", int'(srcAPhys[0]), 4*i);
      chk("R1 reset map", int'(srcBPhys[0]), 4*i+1);
      chk("R1 reset map", int'(srcAPhys[1]), 4*i+2);
      chk("R1 reset map", int'(srcBPhys[1]), 4*i+3);
    end

    // Vector table: R2 R3 R4 R5 R6 R7 R8
    for (int n = 0; n < 9; n++) begin
      drive(VECS[n].vld, VECS[n].dv, VECS[n].sa0, VECS[n].sb0, VECS[n].d0,
            VECS[n].sa1, VECS[n].sb1, VECS[n].d1, VECS[n].rel, VECS[n].rp0, VECS[n].rp1);
      chk($sformatf("R7 stall vec%0d", n), int'(stall), int'(VECS[n].eStall));
      if (!VECS[n].eStall) begin
        if (VECS[n].vld[0]) begin
          chk($sformatf("R2 lane0 srcA vec%0d", n), int'(srcAPhys[0]), int'(VECS[n].eSa0));
          chk($sformatf("R2 lane0 srcB vec%0d", n), int'(srcBPhys[0]), int'(VECS[n].eSb0));
          if (VECS[n].dv[0]) begin
            chk($sformatf("R3 lane0 new vec%0d", n), int'(newPhys[0]), int'(VECS[n].eNew0));
            chk($sformatf("R4 lane0 old vec%0d", n), int'(oldPhys[0]), int'(VECS[n].eOld0));
          end
        end
        if (VECS[n].vld[1]) begin
          chk($sformatf("R5 lane1 srcA vec%0d", n), int'(srcAPhys[1]), int'(VECS[n].eSa1));
          chk($sformatf("R5 lane1 srcB vec%0d", n), int'(srcBPhys[1]), int'(VECS[n].eSb1));
          if (VECS[n].dv[1]) begin
            chk($sformatf("R3 lane1 new vec%0d", n), int'(newPhys[1]), int'(VECS[n].eNew1));
            chk($sformatf("R6 lane1 old vec%0d", n), int'(oldPhys[1]), int'(VECS[n].eOld1));
          end
        end
      end
    end

    // Second reset restores the identity map (R1)
    doReset();
    drive(2'b11, 2'b00, 3'd1, 3'd5, 3'd0, 3'd6, 3'd0, 3'd0, 2'b00, 4'd0, 4'd0);
    chk("R1 map after re-reset r1", int'(srcAPhys[0]), 1);
    chk("R1 map after re-reset r5", int'(srcBPhys[0]), 5);
    chk("R1 map after re-reset r6", int'(srcAPhys[1]), 6);

    // R9 lane0 reads only, lane1 writes and gets the lowest free register
    drive(2'b11, 2'b10, 3'd0, 3'd1, 3'd0, 3'd0, 3'd2, 3'd0, 2'b00, 4'd0, 4'd0);
    chk("R9 stall", int'(stall), 0);
    chk("R9 lane1 new", int'(newPhys[1]), 8);
    chk("R9 lane1 old", int'(oldPhys[1]), 0);

    drive(2'b11, 2'b11, 3'd0, 3'd0, 3'd1, 3'd0, 3'd0, 3'd2, 2'b00, 4'd0, 4'd0);
    chk("R3 pair new lane0", int'(newPhys[0]), 9);
    chk("R3 pair new lane1", int'(newPhys[1]), 10);

    // R7 one free register, two writers
    drive(2'b11, 2'b11, 3'd0, 3'd0, 3'd3, 3'd0, 3'd0, 3'd4, 2'b00, 4'd0, 4'd0);
    chk("R7 stall with one free two writers", int'(stall), 1);

    // R7 one free, one writer in lane1
    drive(2'b10, 2'b10, 3'd0, 3'd0, 3'd0, 3'd3, 3'd3, 3'd3, 2'b00, 4'd0, 4'd0);
    chk("R7 exact fit stall", int'(stall), 0);
    chk("R7 exact fit new", int'(newPhys[1]), 11);
    chk("R7 exact fit old", int'(oldPhys[1]), 3);

    // R8 pool empty: stall while releasing 0 and 3
    drive(2'b01, 2'b01, 3'd4, 3'd4, 3'd4, 3'd0, 3'd0, 3'd0, 2'b11, 4'd0, 4'd3);
    chk("R8 same-cycle release not usable", int'(stall), 1);

    drive(2'b11, 2'b11, 3'd4, 3'd0, 3'd4, 3'd4, 3'd5, 3'd5, 2'b00, 4'd0, 4'd0);
    chk("R8 released reuse stall", int'(stall), 0);
    chk("R8 released reuse lane0", int'(newPhys[0]), 0);
    chk("R8 released reuse lane1", int'(newPhys[1]), 3);
    chk("R8 lane0 old", int'(oldPhys[0]), 4);
    chk("R8 lane1 srcA forwarded", int'(srcAPhys[1]), 0);
    chk("R2 lane0 srcB r0", int'(srcBPhys[0]), 8);

    @(negedge clk);
    reqVld = '0; relVld = '0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule